// File: doc/BRIEF.md
# Sixteen-Bit Up/Down Timer with Two PWM Compare Channels

This block is a 16-bit timer-counter that advances on a selectable timer tick and compares its count against two compare registers. The tick comes from a free-running prescaler on the system clock (divide by 1, 8, 64 or 256), from either edge of a synchronized external pin, or from nothing, in which case the count holds.

Eight counting modes cover a plain free-running count, single-slope PWM with a fixed end value of 0x00FF, 0x01FF or 0x03FF, single-slope PWM whose end value comes from compare register A or from the capture register, and dual-slope PWM whose turning point comes from either register. In every mode other than the plain one, compare writes land in a shadow copy and reach the comparators only at a safe point in the period. That point is the end of the period for single-slope modes and the low turning point for dual-slope modes. This lets duty cycle and period change while the timer runs, with no glitch.

Software configures the block through a single-cycle write port. Three sticky flags report the compare matches and the period wrap, and a mask selects which of them raise the interrupt line.

Top module: `pwm_timer16`

## Requirements
- R1: After reset the count, flags, interrupt line, both wave outputs and all configuration are zero, and the timer is stopped.
- R2: Write address map: 0 control, 1 compare A, 2 compare B, 3 capture/period register, 4 count, 5 interrupt mask, 6 flag clear. Control bits [2:0] select the clock, bits [5:3] the mode, bits [7:6] the channel A output mode and bits [9:8] the channel B output mode. Mode 0 counts 0 to 0xFFFF and wraps to 0. In mode 0, compare writes take effect on the next cycle.
- R3: Modes 1, 2 and 3 count from 0 up to 0x00FF, 0x01FF and 0x03FF respectively and then restart at 0. Mode 4 restarts after the active compare A value, and mode 5 after the capture register value. A count above the end value runs on to 0xFFFF and wraps.
- R4: Clock select 0 or 7 stops the timer, and the count holds its value.
- R5: Clock select 1, 2, 3 and 4 give one tick every 1, 8, 64 and 256 clocks. Select 6 counts rising edges and select 5 counts falling edges of the external pin after a two-stage synchronizer. The count moves by at most one step per clock, unless software writes it.
- R6: In modes 1 to 7, compare writes go to a shadow register. Single-slope modes copy the shadow into the active value on the tick that ends the period. Dual-slope modes copy it on the tick taken at count 0.
- R7: Modes 6 and 7 count up to the compare A value or the capture register value respectively, then count down to 0, then count up again. A full period is twice the end value in ticks.
- R8: Flag bit 0 (A) and bit 1 (B) set on a tick taken while the count equals that channel's active compare value. Bit 2 sets when a single-slope or normal count wraps, or when a dual-slope count turns at 0. Writing a one to a bit at address 6 clears it. A set event in the same cycle wins.
- R9: The interrupt line is high exactly when some flag is set whose mask bit (same bit order) is set.
- R10: In modes 1 to 7, output mode 2 is non-inverting and 3 is inverting. Single-slope: a non-inverting output goes high on the period wrap and low on the tick taken at the compare value, giving compare+1 high ticks per period. Dual-slope: it goes low at the compare value while counting up and high at the compare value while counting down. Output mode 1 toggles on a match. Output mode 0 holds the pin low.
- R11: In modes 4 and 6, channel A with output mode 2 or 3 holds its pin low.
- R12: In mode 0, a match toggles the pin for output mode 1, drives it low for output mode 2, and drives it high for output mode 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| ext_clk_in | input | 1 | External count pin, asynchronous |
| cnt_o | output | 16 | Current count |
| flags_o | output | 3 | Sticky flags {wrap, match B, match A} |
| irq_o | output | 1 | Masked interrupt request |
| wave_a | output | 1 | Channel A compare output |
| wave_b | output | 1 | Channel B compare output |

## Verification
The assertions assume that software never writes the count while the timer runs in a dual-slope mode with a count above the end value. They also assume that the external pin stays at each level for at least three clocks, so the synchronizer sees every edge. The stimulus rewrites the count, the compare registers and the period register only while the clock select is 0. It then starts the timer with a single control write. External pulses are held for four clocks on each level. Run-time compare changes are made only to the shadow registers in PWM modes, which is the case the double buffering exists for.

// File: rtl/pwm_timer16.sv
module pwm_timer16 #(
  parameter int W  = 16,
  parameter int PW = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         ext_clk_in,
  output logic [W-1:0] cnt_o,
  output logic [2:0]   flags_o,
  output logic         irq_o,
  output logic         wave_a,
  output logic         wave_b
);
  localparam logic [2:0] A_CTRL = 3'd0, A_CMPA = 3'd1, A_CMPB = 3'd2, A_CAP = 3'd3,
                         A_CNT = 3'd4, A_MASK = 3'd5, A_CLR = 3'd6;
  localparam logic [W-1:0] TOP8  = W'(16'h00FF);
  localparam logic [W-1:0] TOP9  = W'(16'h01FF);
  localparam logic [W-1:0] TOP10 = W'(16'h03FF);

  logic [W-1:0]  cnt_q, buf_a, buf_b, act_a, act_b, cap_q, top;
  logic [2:0]    sel_q, mode_q, mask_q, flag_q, xs;
  logic [1:0]    coma_q, comb_q;
  logic [PW-1:0] pre_q;
  logic          dir_dn, wa_q, wb_q, tick;

  wire wr_ctrl = wr_en && wr_addr == A_CTRL;
  wire wr_a    = wr_en && wr_addr == A_CMPA;
  wire wr_b    = wr_en && wr_addr == A_CMPB;
  wire wr_cap  = wr_en && wr_addr == A_CAP;
  wire wr_cnt  = wr_en && wr_addr == A_CNT;
  wire wr_mask = wr_en && wr_addr == A_MASK;
  wire wr_clr  = wr_en && wr_addr == A_CLR;

  wire normal = mode_q == 3'd0;
  wire dual   = mode_q[2:1] == 2'b11;
  wire a_top  = mode_q == 3'd4 || mode_q == 3'd6;

  wire ext_rise = xs[1] & ~xs[2];
  wire ext_fall = ~xs[1] & xs[2];

  always_comb begin
    case (sel_q)
      3'd1:    tick = 1'b1;
      3'd2:    tick = &pre_q[2:0];
      3'd3:    tick = &pre_q[5:0];
      3'd4:    tick = &pre_q[7:0];
      3'd5:    tick = ext_fall;
      3'd6:    tick = ext_rise;
      default: tick = 1'b0;
    endcase
  end

  always_comb begin
    case (mode_q)
      3'd1:        top = TOP8;
      3'd2:        top = TOP9;
      3'd3:        top = TOP10;
      3'd4, 3'd6:  top = act_a;
      3'd5, 3'd7:  top = cap_q;
      default:     top = '1;
    endcase
  end

  wire at_top = cnt_q == top;
  wire at_max = &cnt_q;
  wire at_bot = cnt_q == '0;
  wire wrap   = tick && !dual && (at_top || at_max);
  wire bounce = tick && dual && at_bot && dir_dn;
  wire upd    = tick && !normal && (dual ? at_bot : (at_top || at_max));
  wire hit_a  = tick && cnt_q == act_a;
  wire hit_b  = tick && cnt_q == act_b;

  function automatic logic wave_next(input logic cur, input logic [1:0] com,
                                     input logic hit, input logic blk,
                                     input logic nrm, input logic dsl,
                                     input logic wrp, input logic down);
    logic r;
    r = cur;
    if (com == 2'd0 || blk)      r = 1'b0;
    else if (nrm) begin
      if (hit) r = (com == 2'd1) ? ~cur : (com == 2'd3);
    end else if (com == 2'd1) begin
      if (hit) r = ~cur;
    end else if (dsl) begin
      if (hit) r = down ? (com == 2'd2) : (com == 2'd3);
    end else if (wrp)            r = (com == 2'd2);
    else if (hit)                r = (com == 2'd3);
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      xs    <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
      xs    <= {xs[1:0], ext_clk_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      mode_q <= '0;
      coma_q <= '0;
      comb_q <= '0;
      mask_q <= '0;
      cap_q  <= '0;
    end else begin
      if (wr_ctrl) {comb_q, coma_q, mode_q, sel_q} <= wr_data[9:0];
      if (wr_mask) mask_q <= wr_data[2:0];
      if (wr_cap)  cap_q  <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_a <= '0;
      buf_b <= '0;
      act_a <= '0;
      act_b <= '0;
    end else begin
      if (wr_a) buf_a <= wr_data;
      if (wr_b) buf_b <= wr_data;
      if (normal && wr_a)  act_a <= wr_data;
      else if (upd)        act_a <= buf_a;
      if (normal && wr_b)  act_b <= wr_data;
      else if (upd)        act_b <= buf_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      dir_dn <= 1'b0;
    end else if (wr_cnt) begin
      cnt_q  <= wr_data;
      dir_dn <= 1'b0;
    end else if (!dual) begin
      dir_dn <= 1'b0;
      if (tick) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end else if (tick) begin
      if (dir_dn) begin
        if (at_bot) begin
          dir_dn <= 1'b0;
          cnt_q  <= cnt_q + 1'b1;
        end else cnt_q <= cnt_q - 1'b1;
      end else if (cnt_q >= top && !at_bot) begin
        dir_dn <= 1'b1;
        cnt_q  <= cnt_q - 1'b1;
      end else cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~({3{wr_clr}} & wr_data[2:0])) |
                          {wrap || bounce, hit_b, hit_a};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wa_q <= 1'b0;
      wb_q <= 1'b0;
    end else begin
      wa_q <= wave_next(wa_q, coma_q, hit_a, a_top && coma_q[1], normal, dual, wrap, dir_dn);
      wb_q <= wave_next(wb_q, comb_q, hit_b, 1'b0, normal, dual, wrap, dir_dn);
    end
  end

  assign cnt_o   = cnt_q;
  assign flags_o = flag_q;
  assign irq_o   = |(flag_q & mask_q);
  assign wave_a  = wa_q;
  assign wave_b  = wb_q;

  assert_hold_when_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_cnt) |=> cnt_q == $past(cnt_q));

  assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cnt |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1 ||
                 cnt_q == $past(cnt_q) - 1'b1 || cnt_q == '0));

  assert_restart_at_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !dual && !normal && at_top && !wr_cnt) |=> cnt_q == '0);

  assert_shadow_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!normal && !upd && !wr_ctrl) |=> (act_a == $past(act_a) && act_b == $past(act_b)));

  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> flag_q != '0);

  assert_blocked_pin_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (a_top && coma_q[1] && !wr_ctrl) |=> !wave_a);

  assert_wrap_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !wr_cnt) |=> flag_q[2]);
endmodule

// File: tb/sim_pwm_timer16.sv
`timescale 1ns/1ps
module sim_pwm_timer16;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, ext_clk_in = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] cnt_o;
  logic [2:0]  flags_o;
  logic        irq_o, wave_a, wave_b;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  pwm_timer16 u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                  .wr_data(wr_data), .ext_clk_in(ext_clk_in), .cnt_o(cnt_o),
                  .flags_o(flags_o), .irq_o(irq_o), .wave_a(wave_a), .wave_b(wave_b));

  // {mode, compare A, capture, ticks, expected count}
  localparam logic [79:0] VEC [8] = '{
    {16'd0, 16'd0,  16'd0,  16'd300,  16'd300},
    {16'd1, 16'd0,  16'd0,  16'd300,  16'd44},
    {16'd2, 16'd0,  16'd0,  16'd600,  16'd88},
    {16'd3, 16'd0,  16'd0,  16'd1100, 16'd76},
    {16'd4, 16'd99, 16'd0,  16'd250,  16'd50},
    {16'd5, 16'd0,  16'd49, 16'd123,  16'd23},
    {16'd6, 16'd10, 16'd0,  16'd25,   16'd5},
    {16'd7, 16'd0,  16'd10, 16'd33,   16'd7}
  };

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ctl(input int mode, input int ca, input int cb, input int sel);
    wr(3'd0, 16'(((cb & 3) << 8) | ((ca & 3) << 6) | ((mode & 7) << 3) | (sel & 7)));
  endtask

  task automatic setup(input int oa, input int ob, input int ic);
    ctl(0, 0, 0, 0);
    wr(3'd1, 16'(oa)); wr(3'd2, 16'(ob)); wr(3'd3, 16'(ic));
    wr(3'd4, 16'd0);   wr(3'd6, 16'd7);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_high(input int n, output int ha, output int hb);
    ha = 0; hb = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ha += int'(wave_a);
      hb += int'(wave_b);
    end
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int ha, hb, c0;
    idle(3);
    chk("R1 count", int'(cnt_o), 0);
    chk("R1 flags", int'(flags_o), 0);
    chk("R1 irq/waves", int'({irq_o, wave_a, wave_b}), 0);
    rst_n = 1'b1;
    idle(5);
    chk("R1 stopped after reset", int'(cnt_o), 0);

    for (int v = 0; v < 8; v++) begin
      int md;
      md = int'(VEC[v][79:64]);
      setup(int'(VEC[v][63:48]), 0, int'(VEC[v][47:32]));
      ctl(md, 0, 0, 1);
      idle(int'(VEC[v][31:16]));
      chk(md == 0 ? "R2 vector" : (md >= 6 ? "R7 vector" : "R3 vector"),
          int'(cnt_o), int'(VEC[v][15:0]));
    end

    // R4: both stop codes hold the count
    setup(0, 0, 0); wr(3'd4, 16'd77);
    ctl(0, 0, 0, 0); idle(20);
    chk("R4 sel0 hold", int'(cnt_o), 77);
    ctl(0, 0, 0, 7); idle(20);
    chk("R4 sel7 hold", int'(cnt_o), 77);

    // R5: prescaler ratios
    setup(0, 0, 0); ctl(0, 0, 0, 2); c0 = int'(cnt_o); idle(64);
    chk("R5 div8", int'(cnt_o) - c0, 8);
    setup(0, 0, 0); ctl(0, 0, 0, 3); c0 = int'(cnt_o); idle(256);
    chk("R5 div64", int'(cnt_o) - c0, 4);
    setup(0, 0, 0); ctl(0, 0, 0, 4); c0 = int'(cnt_o); idle(512);
    chk("R5 div256", int'(cnt_o) - c0, 2);

    // R5: external pin, rising then falling
    setup(0, 0, 0); ctl(0, 0, 0, 6);
    for (int p = 0; p < 5; p++) begin ext_clk_in = 1'b1; idle(4); ext_clk_in = 1'b0; idle(4); end
    idle(4);
    chk("R5 ext rising", int'(cnt_o), 5);
    setup(0, 0, 0); ctl(0, 0, 0, 5);
    for (int p = 0; p < 5; p++) begin ext_clk_in = 1'b1; idle(4); ext_clk_in = 1'b0; idle(4); end
    idle(4);
    chk("R5 ext falling", int'(cnt_o), 5);
    ext_clk_in = 1'b1; idle(20);
    chk("R5 held pin no count", int'(cnt_o), 5);
    ext_clk_in = 1'b0;

    // R8/R9: compare flags, mask, clear
    setup(5, 200, 0); wr(3'd5, 16'd0);
    ctl(0, 0, 0, 1); idle(10); ctl(0, 0, 0, 0);
    chk("R8 match A flag only", int'(flags_o), 1);
    chk("R9 masked irq low", int'(irq_o), 0);
    wr(3'd5, 16'd1);
    chk("R9 irq high with mask", int'(irq_o), 1);
    wr(3'd6, 16'd1);
    chk("R8 clear by one", int'(flags_o), 0);
    chk("R9 irq drops", int'(irq_o), 0);
    wr(3'd5, 16'd0);

    // R8: wrap flag at fixed 8-bit end
    setup(0, 0, 0); ctl(1, 0, 0, 1); idle(255);
    chk("R8 no wrap yet", int'(flags_o[2]), 0);
    idle(1);
    chk("R8 wrap flag", int'(flags_o[2]), 1);
    chk("R3 restart at 0", int'(cnt_o), 0);

    // R6: shadowed period change in mode 4
    setup(99, 0, 0); ctl(4, 0, 0, 1); idle(20);
    wr(3'd1, 16'd39); idle(80);
    chk("R6 old period kept", int'(cnt_o), 1);
    idle(40);
    chk("R6 new period after wrap", int'(cnt_o), 1);

    // R10: fast PWM non-inverting and inverting
    setup(0, 63, 0); ctl(1, 0, 2, 1); idle(256);
    count_high(256, ha, hb);
    chk("R10 non-inverting duty", hb, 64);
    setup(0, 63, 0); ctl(1, 0, 3, 1); idle(256);
    count_high(256, ha, hb);
    chk("R10 inverting duty", hb, 192);

    // R11: channel A blocked when it sets the period
    setup(99, 49, 0); ctl(4, 2, 2, 1); idle(100);
    count_high(200, ha, hb);
    chk("R11 wave A low", ha, 0);
    chk("R10 wave B duty mode4", hb, 100);

    // R10: toggle in PWM, dual-slope duty
    setup(10, 0, 49); ctl(5, 1, 0, 1); idle(50);
    count_high(100, ha, hb);
    chk("R10 toggle half duty", ha, 50);
    setup(0, 25, 100); ctl(7, 0, 2, 1); idle(200);
    count_high(200, ha, hb);
    chk("R10 dual-slope duty", hb, 50);

    // R12: normal mode set then toggle
    setup(0, 5, 0); ctl(0, 0, 3, 1); idle(10); ctl(0, 0, 3, 0);
    chk("R12 set on match", int'(wave_b), 1);
    wr(3'd4, 16'd0); ctl(0, 0, 1, 1); idle(10); ctl(0, 0, 1, 0);
    chk("R12 toggle on match", int'(wave_b), 0);
    wr(3'd4, 16'd0); ctl(0, 0, 2, 1); idle(10); ctl(0, 0, 2, 0);
    chk("R12 clear on match", int'(wave_b), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule